// File: doc/BRIEF.md
# Sampled AXI Byte Throughput Monitor

This block listens passively to the handshake signals of up to eight AXI memory-mapped slave ports, three by default. For each port it counts the bytes that move on the read-data channel and on the write-data channel. A read beat is worth the full bus width in bytes. A write beat is worth the number of its enabled byte lanes. The block never drives the observed buses.

Counting runs over a sample window whose length is programmed in clock cycles. When the window closes, every running total is copied into a stable metric register and the totals restart from zero. A sticky completion flag and the interrupt line are also raised. Software polls that flag, selects a port, reads each 64-bit metric as two 32-bit halves, and clears the flag by writing one to it. If a window closes while the flag is still set, a second sticky flag reports that a sample was missed.

Register words, selected by `wr_addr` and `rd_addr`: 0 = window length in cycles (read/write); 1 = control, bit 0 enables counting (read/write); 2 = status, bit 0 sample done, bit 1 overrun (write one to clear); 3 = reads as zero; 4 and 5 = read bytes, low and high half; 6 and 7 = written bytes, low and high half. The metric words 4 to 7 belong to the port selected by `rd_port`.

Top module: `axi_tput_mon`

## Requirements
- R1: After reset the window length, the enable bit, both status bits, `irq` and every metric word of every port read as zero.
- R2: A read beat adds DATA_BYTES to the port's read total in a cycle where its `rvalid` and `rready` are both high. With either signal low the beat adds nothing.
- R3: A write beat adds the count of set bits in the port's `wstrb` slice (bits p*DATA_BYTES to p*DATA_BYTES+DATA_BYTES-1) in a cycle where `wvalid` and `wready` are both high. With either signal low the beat adds nothing.
- R4: With the enable bit set and a window length N of 1 or more, the window counter starts at zero in the cycle after enabling and a window closes every N cycles. The first close happens at the clock edge that ends the N-th cycle after the enabling write.
- R5: When a window closes, each port's metric words take the totals of that window and the totals restart. A beat in the closing cycle counts toward the next window.
- R6: A window close sets status bit 0, and `irq` follows that bit. Writing a 1 to bit 0 of word 2 clears it, and a set from a close in the same cycle takes priority.
- R7: A window close while status bit 0 is still set, and not cleared in that cycle, sets status bit 1. Status bit 1 is cleared by writing a 1 to bit 1 of word 2.
- R8: The running totals are ACC_W bits wide and stay at all ones instead of wrapping when they would exceed their range.
- R9: The high metric words return total bits 63 to 32, zero-extended. Selecting a port number at or above NPORT returns zero in words 4 to 7.
- R10: Each port's totals depend only on that port's own handshake and strobe signals.
- R11: With the enable bit clear, no window closes, the totals are held at zero and beats are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rvalid | input | NPORT | Read-data valid, one bit per port |
| rready | input | NPORT | Read-data ready, one bit per port |
| wvalid | input | NPORT | Write-data valid, one bit per port |
| wready | input | NPORT | Write-data ready, one bit per port |
| wstrb | input | NPORT*DATA_BYTES | Write strobes, port p in slice p |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word |
| rd_port | input | 3 | Port select for metric words |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Sample-done interrupt, equal to status bit 0 |

## Verification
The properties assume that every observed handshake and strobe input holds a known 0 or 1 at each clock edge. They also assume that the register interface writes status only with `wr_en` high, so a clear and a window close can meet only through the documented priority. The stimulus changes every input only on the falling clock edge and never leaves an input undriven. It programs window lengths of at least one cycle, so the first-window arithmetic of R4 stays in the range the counter properties cover.

// File: rtl/axi_tput_pkg.sv
package axi_tput_pkg;
    localparam int REG_AW = 3;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] A_WINDOW = 3'd0;
    localparam logic [REG_AW-1:0] A_CTRL   = 3'd1;
    localparam logic [REG_AW-1:0] A_STATUS = 3'd2;
    localparam logic [REG_AW-1:0] A_RD_LO  = 3'd4;
    localparam logic [REG_AW-1:0] A_RD_HI  = 3'd5;
    localparam logic [REG_AW-1:0] A_WR_LO  = 3'd6;
    localparam logic [REG_AW-1:0] A_WR_HI  = 3'd7;
endpackage

// File: rtl/tput_window_timer.sv
module tput_window_timer #(
    parameter int IVL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [IVL_W-1:0] win_len,
    output logic             expire
);
    logic [IVL_W-1:0] cnt_d, cnt_q;
    logic [IVL_W-1:0] last;

    always_comb begin
        last   = (win_len == '0) ? '0 : win_len - 1'b1;
        expire = run && (cnt_q >= last);
        cnt_d  = cnt_q + 1'b1;
        if (!run || expire) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));
    a_r11_idle_counter: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/tput_port_acc.sv
module tput_port_acc #(
    parameter int DATA_BYTES = 8,
    parameter int ACC_W      = 48
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  expire,
    input  logic                  rd_beat,
    input  logic                  wr_beat,
    input  logic [DATA_BYTES-1:0] strb,
    output logic [ACC_W-1:0]      rd_snap,
    output logic [ACC_W-1:0]      wr_snap
);
    typedef struct packed {
        logic [ACC_W-1:0] rd_acc;
        logic [ACC_W-1:0] wr_acc;
        logic [ACC_W-1:0] rd_snap;
        logic [ACC_W-1:0] wr_snap;
    } acc_t;

    acc_t st_d, st_q;
    logic [ACC_W-1:0] rd_inc, wr_inc;

    function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                                 input logic [ACC_W-1:0] b);
        logic [ACC_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[ACC_W] ? {ACC_W{1'b1}} : s[ACC_W-1:0];
    endfunction

    always_comb begin
        rd_inc = rd_beat ? ACC_W'(DATA_BYTES) : '0;
        wr_inc = '0;
        for (int i = 0; i < DATA_BYTES; i++) begin
            wr_inc = wr_inc + ACC_W'(strb[i] & wr_beat);
        end

        st_d = st_q;
        if (!run) begin
            st_d.rd_acc = '0;
            st_d.wr_acc = '0;
        end else if (expire) begin
            st_d.rd_snap = st_q.rd_acc;
            st_d.wr_snap = st_q.wr_acc;
            st_d.rd_acc  = rd_inc;
            st_d.wr_acc  = wr_inc;
        end else begin
            st_d.rd_acc = sat_add(st_q.rd_acc, rd_inc);
            st_d.wr_acc = sat_add(st_q.wr_acc, wr_inc);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_snap = st_q.rd_snap;
    assign wr_snap = st_q.wr_snap;

    a_r8_no_wrap_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !expire) |=> (st_q.rd_acc >= $past(st_q.rd_acc)));
    a_r8_no_wrap_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !expire) |=> (st_q.wr_acc >= $past(st_q.wr_acc)));
    a_r5_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        (run && expire) |=> (st_q.rd_snap == $past(st_q.rd_acc)) &&
                            (st_q.wr_snap == $past(st_q.wr_acc)));
    a_r11_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.rd_acc == '0) && (st_q.wr_acc == '0));
endmodule

// File: rtl/axi_tput_mon.sv
module axi_tput_mon
    import axi_tput_pkg::*;
#(
    parameter int NPORT      = 3,
    parameter int DATA_BYTES = 8,
    parameter int ACC_W      = 48,
    parameter int IVL_W      = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPORT-1:0]            rvalid,
    input  logic [NPORT-1:0]            rready,
    input  logic [NPORT-1:0]            wvalid,
    input  logic [NPORT-1:0]            wready,
    input  logic [NPORT*DATA_BYTES-1:0] wstrb,
    input  logic                        wr_en,
    input  logic [2:0]                  wr_addr,
    input  logic [31:0]                 wr_data,
    input  logic [2:0]                  rd_addr,
    input  logic [2:0]                  rd_port,
    output logic [31:0]                 rd_data,
    output logic                        irq
);
    localparam int MET_W = 64;

    typedef struct packed {
        logic [IVL_W-1:0] win_len;
        logic             run;
        logic             done;
        logic             ovr;
    } regs_t;

    regs_t r_d, r_q;
    logic  expire;
    logic  clr_done, clr_ovr;
    logic [ACC_W-1:0] rd_snap [NPORT];
    logic [ACC_W-1:0] wr_snap [NPORT];
    logic [MET_W-1:0] sel_rd, sel_wr;

    tput_window_timer #(.IVL_W(IVL_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.run),
        .win_len (r_q.win_len),
        .expire  (expire)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        tput_port_acc #(.DATA_BYTES(DATA_BYTES), .ACC_W(ACC_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (r_q.run),
            .expire  (expire),
            .rd_beat (rvalid[p] & rready[p]),
            .wr_beat (wvalid[p] & wready[p]),
            .strb    (wstrb[p*DATA_BYTES +: DATA_BYTES]),
            .rd_snap (rd_snap[p]),
            .wr_snap (wr_snap[p])
        );
    end

    always_comb begin
        clr_done = wr_en && (wr_addr == A_STATUS) && wr_data[0];
        clr_ovr  = wr_en && (wr_addr == A_STATUS) && wr_data[1];

        r_d = r_q;
        if (wr_en && wr_addr == A_WINDOW) r_d.win_len = wr_data[IVL_W-1:0];
        if (wr_en && wr_addr == A_CTRL)   r_d.run     = wr_data[0];

        if (expire)        r_d.done = 1'b1;
        else if (clr_done) r_d.done = 1'b0;

        if (expire && r_q.done && !clr_done) r_d.ovr = 1'b1;
        else if (clr_ovr)                    r_d.ovr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        sel_rd = '0;
        sel_wr = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (int'(rd_port) == p) begin
                sel_rd = MET_W'(rd_snap[p]);
                sel_wr = MET_W'(wr_snap[p]);
            end
        end
        case (rd_addr)
            A_WINDOW: rd_data = 32'(r_q.win_len);
            A_CTRL:   rd_data = {31'd0, r_q.run};
            A_STATUS: rd_data = {30'd0, r_q.ovr, r_q.done};
            A_RD_LO:  rd_data = sel_rd[31:0];
            A_RD_HI:  rd_data = sel_rd[63:32];
            A_WR_LO:  rd_data = sel_wr[31:0];
            A_WR_HI:  rd_data = sel_wr[63:32];
            default:  rd_data = '0;
        endcase
    end

    assign irq = r_q.done;

    a_r6_done_set: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> r_q.done);
    a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && r_q.done && !clr_done) |=> r_q.ovr);
    a_r11_no_close_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.run |-> !expire);
endmodule

// File: tb/sim_axi_tput_mon.sv
module sim_axi_tput_mon;
    localparam int NP = 3;
    localparam int DB = 8;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] rvalid = '0, rready = '0, wvalid = '0, wready = '0;
    logic [NP*DB-1:0] wstrb = '0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0, rd_port = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    axi_tput_mon #(.NPORT(NP), .DATA_BYTES(DB), .ACC_W(AW), .IVL_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .rvalid(rvalid), .rready(rready),
        .wvalid(wvalid), .wready(wready), .wstrb(wstrb), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_port(rd_port), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, input logic [2:0] p, output logic [31:0] d);
        rd_addr = a; rd_port = p;
        #1 d = rd_data;
    endtask

    task automatic idle_bus();
        rvalid = '0; rready = '0; wvalid = '0; wready = '0; wstrb = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            for (int p = 0; p < NP; p++) begin
                rreg(3'(a), 3'(p), v);
                chk("R1 register after reset", v, 0);
            end
        end
        chk("R1 irq after reset", {31'd0, irq}, 0);
    endtask

    // Window 20, port 0: gated and ungated beats, first close timing.
    task automatic t_basic();
        logic [31:0] v;
        wreg(3'd0, 20);
        wreg(3'd1, 1);
        for (int c = 0; c < 20; c++) begin
            idle_bus();
            if (c < 5)  begin rvalid[0] = 1; rready[0] = 1; end
            if (c == 5) begin rvalid[0] = 1; rready[0] = 0; end
            if (c == 6) begin rvalid[0] = 0; rready[0] = 1; end
            if (c < 4)  begin wvalid[0] = 1; wready[0] = (c != 3); end
            if (c == 0) wstrb[7:0] = 8'hFF;
            if (c == 1) wstrb[7:0] = 8'h0F;
            if (c == 2) wstrb[7:0] = 8'h01;
            if (c == 3) wstrb[7:0] = 8'hFF;
            if (c == 19) chk("R4 no close before N cycles", {31'd0, irq}, 0);
            @(negedge clk);
        end
        idle_bus();
        chk("R4 close after N cycles", {31'd0, irq}, 1);
        rreg(3'd2, 3'd0, v); chk("R6 status done", v, 1);
        rreg(3'd4, 3'd0, v); chk("R2 read bytes", v, 40);
        rreg(3'd6, 3'd0, v); chk("R3 write bytes by strobe", v, 13);
        rreg(3'd5, 3'd0, v); chk("R9 read high half", v, 0);
        wreg(3'd2, 1);
        chk("R6 irq cleared by W1C", {31'd0, irq}, 0);
    endtask

    // Continues t_basic at cycle 21: closing-cycle beat and overrun.
    task automatic t_edge_overrun();
        logic [31:0] v;
        for (int c = 21; c < 40; c++) begin
            idle_bus();
            if (c == 38) begin wvalid[0] = 1; wready[0] = 1; wstrb[7:0] = 8'h03; end
            if (c == 39) begin rvalid[0] = 1; rready[0] = 1; end
            @(negedge clk);
        end
        idle_bus();
        rreg(3'd4, 3'd0, v); chk("R5 closing-cycle beat excluded", v, 0);
        rreg(3'd6, 3'd0, v); chk("R5 beat before close included", v, 2);
        rreg(3'd2, 3'd0, v); chk("R7 no overrun yet", v, 1);
        for (int c = 40; c < 60; c++) @(negedge clk);
        rreg(3'd2, 3'd0, v); chk("R7 overrun set", v, 3);
        rreg(3'd4, 3'd0, v); chk("R5 closing-cycle beat in next window", v, 8);
        rreg(3'd6, 3'd0, v); chk("R5 totals restarted", v, 0);
        wreg(3'd2, 3);
        rreg(3'd2, 3'd0, v); chk("R7 both bits cleared", v, 0);
    endtask

    task automatic t_ports();
        logic [31:0] v;
        wreg(3'd1, 0);
        wreg(3'd0, 10);
        wreg(3'd1, 1);
        for (int c = 0; c < 10; c++) begin
            idle_bus();
            if (c < 4) begin wvalid[1] = 1; wready[1] = 1; wstrb[15:8] = 8'hF0; end
            if (c < 2) begin rvalid[2] = 1; rready[2] = 1; end
            if (c == 0) begin wvalid[2] = 1; wready[2] = 1; wstrb[23:16] = 8'h80; end
            @(negedge clk);
        end
        idle_bus();
        rreg(3'd4, 3'd0, v); chk("R10 port0 read", v, 0);
        rreg(3'd6, 3'd0, v); chk("R10 port0 write", v, 0);
        rreg(3'd4, 3'd1, v); chk("R10 port1 read", v, 0);
        rreg(3'd6, 3'd1, v); chk("R10 port1 write", v, 16);
        rreg(3'd4, 3'd2, v); chk("R10 port2 read", v, 16);
        rreg(3'd6, 3'd2, v); chk("R10 port2 write", v, 1);
        rreg(3'd4, 3'd3, v); chk("R9 unused port select", v, 0);
        rreg(3'd7, 3'd2, v); chk("R9 write high half", v, 0);
        wreg(3'd2, 3);
    endtask

    task automatic t_saturate();
        logic [31:0] v;
        wreg(3'd1, 0);
        wreg(3'd0, 200);
        wreg(3'd1, 1);
        for (int c = 0; c < 200; c++) begin
            idle_bus();
            if (c < 130) begin rvalid[0] = 1; rready[0] = 1; end
            @(negedge clk);
        end
        idle_bus();
        rreg(3'd4, 3'd0, v); chk("R8 saturated total", v, (1 << AW) - 1);
        wreg(3'd2, 3);
    endtask

    task automatic t_stopped();
        logic [31:0] v;
        wreg(3'd1, 0);
        wreg(3'd0, 5);
        for (int c = 0; c < 30; c++) begin
            rvalid[0] = 1; rready[0] = 1;
            @(negedge clk);
        end
        idle_bus();
        chk("R11 no close while disabled", {31'd0, irq}, 0);
        rreg(3'd2, 3'd0, v); chk("R11 status idle", v, 0);
        wreg(3'd1, 1);
        for (int c = 0; c < 5; c++) @(negedge clk);
        chk("R4 close after restart", {31'd0, irq}, 1);
        rreg(3'd4, 3'd0, v); chk("R11 beats while disabled ignored", v, 0);
    endtask

    initial begin
        idle_bus();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_edge_overrun();
        t_ports();
        t_saturate();
        t_stopped();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule